// File: doc/BRIEF.md
# Grouped Micro-op Scheduler Buffer

This block is an in-order holding buffer that sits between the instruction decoders and retirement. Each entry is a group of four micro-op slots. The decoders may present one group per clock. When a group arrives with fewer than four real micro-ops, the block fills the unused slots with NOPs. NOP slots carry a zero payload and count as finished from the moment they are written.

Execution units report completion one slot at a time. Each report carries the group tag that the buffer handed out at allocation. The oldest group leaves the buffer as soon as every one of its four slots is finished, and at most one group leaves per clock. When all six entries are occupied, the decoders see backpressure. A group may still enter in the same clock in which the oldest group leaves.

A flush input names one live group. It discards every group younger than that group and keeps the named group and everything older.

Top module: `gsb_group_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o` is 1, `retire_valid_o` is 0 and `alloc_tag_o` is 0.
- R2: A group is accepted at a rising edge where `alloc_valid_i` and `alloc_ready_o` are both 1. It receives the tag shown on `alloc_tag_o` in that cycle. Tags are handed out in ring order 0,1,...,5,0.
- R3: The buffer holds at most 6 groups. With 6 groups live and no group retiring in the current cycle, `alloc_ready_o` is 0.
- R4: `alloc_cnt_i` = n (0..4) means slots 0..n-1 hold real micro-ops and slots n..3 are NOPs. A NOP slot has its bit set in `retire_nop_o` (bit s = slot s), carries zero in its 16-bit payload field (slot s at bits 16s+15:16s of the payload buses), and is complete at allocation.
- R5: `retire_valid_o` is 1 only for the oldest live group, and only when all four of its slots are complete. A younger group that is complete waits behind an older one that is not. Groups retire in allocation order, and `retire_tag_o` names the retiring group.
- R6: The cycle after the last outstanding slot of the oldest group is reported done, `retire_valid_o` is 1. The group leaves at the next rising edge, so at most one group retires per clock.
- R7: A done report marks only the slot it names, in the group named by that slot's tag field (`done_tag_i` bits 3s+2:3s for slot s). A group with any real slot still outstanding does not retire.
- R8: While the buffer is full and the oldest group is retiring, `alloc_ready_o` is 1, and a new group is accepted in that same clock.
- R9: While `flush_i` is 1, `alloc_ready_o` is 0. At that edge every group younger than `flush_tag_i` is discarded and never retires, and the next tag handed out is `flush_tag_i`+1 modulo 6.
- R10: A group allocated with `alloc_cnt_i` = 0 is all NOPs. It retires the cycle after allocation once it is the oldest group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid_i | input | 1 | Decoders present a group |
| alloc_cnt_i | input | 3 | Number of real micro-ops in the group (0..4) |
| alloc_uops_i | input | 64 | Slot payloads, 16 bits per slot |
| alloc_ready_o | output | 1 | Buffer accepts a group this cycle |
| alloc_tag_o | output | 3 | Tag given to a group accepted this cycle |
| done_valid_i | input | 4 | Per-slot completion strobes |
| done_tag_i | input | 12 | Per-slot group tags, 3 bits per slot |
| flush_i | input | 1 | Discard groups younger than `flush_tag_i` |
| flush_tag_i | input | 3 | Youngest group to keep on flush |
| retire_valid_o | output | 1 | Oldest group is complete and retires at this edge |
| retire_tag_o | output | 3 | Tag of the retiring group |
| retire_uops_o | output | 64 | Payloads of the retiring group |
| retire_nop_o | output | 4 | NOP mask of the retiring group |

## Verification
The bench goes after these corner cases:
- Accepting a group in the same cycle that a full buffer retires. A design that checked only occupancy would stall the decoders there.
- A younger group that finishes first. A design that retired any complete group would release it out of order.
- A group with only some of its slots reported done. A design that treated one strobe as completing the whole group would retire it early.
- Flushing, both while younger groups are in flight and while the kept group is itself retiring. A wrong tail or count would either resurrect discarded groups or hand out a repeated tag.
- Partial and all-NOP groups. These expose padding that leaves stale payload or fails to pre-complete the unused slots, which would hang retirement.

A long pseudo-random phase then checks every output, every cycle, against a queue model.

// File: rtl/gsb_pkg.sv
package gsb_pkg;

    // distance of an entry from the oldest entry in a ring of n entries
    function automatic int ring_age(int tag, int head, int n);
        if (tag >= head) return tag - head;
        return tag + n - head;
    endfunction

    // successor of a ring index
    function automatic int ring_next(int idx, int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/gsb_alloc_pad.sv
module gsb_alloc_pad #(
    parameter int SLOTS = 4,
    parameter int UOP_W = 16,
    parameter int CNT_W = 3
) (
    input  logic [CNT_W-1:0]       cnt_i,
    input  logic [SLOTS*UOP_W-1:0] uops_i,
    output logic [SLOTS-1:0]       nop_mask_o,
    output logic [SLOTS*UOP_W-1:0] uops_o
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign nop_mask_o[s] = (cnt_i <= CNT_W'(s));
        assign uops_o[s*UOP_W +: UOP_W] = nop_mask_o[s] ? '0 : uops_i[s*UOP_W +: UOP_W];
    end

endmodule

// File: rtl/gsb_done_decode.sv
module gsb_done_decode #(
    parameter int NUM_GROUPS = 6,
    parameter int SLOTS      = 4,
    parameter int TAG_W      = 3
) (
    input  logic [SLOTS-1:0]                  done_valid_i,
    input  logic [SLOTS*TAG_W-1:0]            done_tag_i,
    input  logic [NUM_GROUPS-1:0]             live_i,
    output logic [NUM_GROUPS-1:0][SLOTS-1:0]  set_mask_o
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign set_mask_o[g][s] = live_i[g] && done_valid_i[s] &&
                                      (done_tag_i[s*TAG_W +: TAG_W] == TAG_W'(g));
        end
    end

endmodule

// File: rtl/gsb_ring_ctrl.sv
module gsb_ring_ctrl #(
    parameter int NUM_GROUPS = 6,
    parameter int TAG_W      = 3,
    parameter int OCC_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_fire_i,
    input  logic                  retire_fire_i,
    input  logic                  flush_i,
    input  logic [TAG_W-1:0]      flush_tag_i,
    output logic [TAG_W-1:0]      head_o,
    output logic [TAG_W-1:0]      tail_o,
    output logic [OCC_W-1:0]      occ_o,
    output logic [NUM_GROUPS-1:0] live_o
);

    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [OCC_W-1:0] occ;
    } ring_t;

    ring_t rg_d, rg_q;

    always_comb begin
        int occ_n;
        rg_d  = rg_q;
        occ_n = int'(rg_q.occ);
        if (retire_fire_i) begin
            rg_d.head = TAG_W'(gsb_pkg::ring_next(int'(rg_q.head), NUM_GROUPS));
            occ_n     = occ_n - 1;
        end
        if (flush_i) begin
            rg_d.tail = TAG_W'(gsb_pkg::ring_next(int'(flush_tag_i), NUM_GROUPS));
            occ_n     = gsb_pkg::ring_age(int'(flush_tag_i), int'(rg_q.head), NUM_GROUPS) + 1
                        - (retire_fire_i ? 1 : 0);
        end else if (alloc_fire_i) begin
            rg_d.tail = TAG_W'(gsb_pkg::ring_next(int'(rg_q.tail), NUM_GROUPS));
            occ_n     = occ_n + 1;
        end
        rg_d.occ = OCC_W'(occ_n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_live
        assign live_o[g] = gsb_pkg::ring_age(g, int'(rg_q.head), NUM_GROUPS) < int'(rg_q.occ);
    end

    assign head_o = rg_q.head;
    assign tail_o = rg_q.tail;
    assign occ_o  = rg_q.occ;

    // R3: occupancy never exceeds the number of groups
    p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.occ <= OCC_W'(NUM_GROUPS));

    // R9: after a flush the next tag follows the kept group
    p_flush_tail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (rg_q.tail == TAG_W'(gsb_pkg::ring_next(int'($past(flush_tag_i)), NUM_GROUPS))));

endmodule

// File: rtl/gsb_group_buffer.sv
module gsb_group_buffer #(
    parameter int NUM_GROUPS = 6,
    parameter int SLOTS      = 4,
    parameter int UOP_W      = 16,
    parameter int TAG_W      = $clog2(NUM_GROUPS),
    parameter int CNT_W      = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   alloc_valid_i,
    input  logic [CNT_W-1:0]       alloc_cnt_i,
    input  logic [SLOTS*UOP_W-1:0] alloc_uops_i,
    output logic                   alloc_ready_o,
    output logic [TAG_W-1:0]       alloc_tag_o,
    input  logic [SLOTS-1:0]       done_valid_i,
    input  logic [SLOTS*TAG_W-1:0] done_tag_i,
    input  logic                   flush_i,
    input  logic [TAG_W-1:0]       flush_tag_i,
    output logic                   retire_valid_o,
    output logic [TAG_W-1:0]       retire_tag_o,
    output logic [SLOTS*UOP_W-1:0] retire_uops_o,
    output logic [SLOTS-1:0]       retire_nop_o
);

    localparam int OCC_W = $clog2(NUM_GROUPS + 1);

    typedef struct packed {
        logic [NUM_GROUPS-1:0][SLOTS-1:0]       nop;
        logic [NUM_GROUPS-1:0][SLOTS-1:0]       done;
        logic [NUM_GROUPS-1:0][SLOTS*UOP_W-1:0] uops;
    } store_t;

    store_t st_d, st_q;

    logic [TAG_W-1:0]                 head_q, tail_q;
    logic [OCC_W-1:0]                 occ_q;
    logic [NUM_GROUPS-1:0]            live;
    logic [NUM_GROUPS-1:0][SLOTS-1:0] set_mask;
    logic [SLOTS-1:0]                 pad_nop;
    logic [SLOTS*UOP_W-1:0]           pad_uops;
    logic                             alloc_fire;

    gsb_alloc_pad #(.SLOTS(SLOTS), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_pad (
        .cnt_i      (alloc_cnt_i),
        .uops_i     (alloc_uops_i),
        .nop_mask_o (pad_nop),
        .uops_o     (pad_uops)
    );

    gsb_done_decode #(.NUM_GROUPS(NUM_GROUPS), .SLOTS(SLOTS), .TAG_W(TAG_W)) u_done (
        .done_valid_i (done_valid_i),
        .done_tag_i   (done_tag_i),
        .live_i       (live),
        .set_mask_o   (set_mask)
    );

    gsb_ring_ctrl #(.NUM_GROUPS(NUM_GROUPS), .TAG_W(TAG_W), .OCC_W(OCC_W)) u_ring (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_fire_i  (alloc_fire),
        .retire_fire_i (retire_valid_o),
        .flush_i       (flush_i),
        .flush_tag_i   (flush_tag_i),
        .head_o        (head_q),
        .tail_o        (tail_q),
        .occ_o         (occ_q),
        .live_o        (live)
    );

    assign retire_valid_o = (occ_q != '0) && (&st_q.done[head_q]);
    assign retire_tag_o   = head_q;
    assign retire_uops_o  = st_q.uops[head_q];
    assign retire_nop_o   = st_q.nop[head_q];
    assign alloc_ready_o  = !flush_i && ((occ_q < OCC_W'(NUM_GROUPS)) || retire_valid_o);
    assign alloc_tag_o    = tail_q;
    assign alloc_fire     = alloc_valid_i && alloc_ready_o;

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            st_d.done[g] = st_q.done[g] | set_mask[g];
        end
        if (alloc_fire) begin
            st_d.nop[tail_q]  = pad_nop;
            st_d.done[tail_q] = pad_nop;
            st_d.uops[tail_q] = pad_uops;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: a group count above the slot count is illegal
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid_i |-> (alloc_cnt_i <= CNT_W'(SLOTS)));

    // R4: a new group starts with exactly its NOP slots complete
    p_alloc_done_init_r4: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |=> (st_q.done[$past(tail_q)] == $past(pad_nop)));

    // R6: a retiring group advances the oldest pointer by one
    p_head_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid_o |=> (head_q == TAG_W'(gsb_pkg::ring_next(int'($past(head_q)), NUM_GROUPS))));

    // R8: a retiring cycle without flush always leaves room
    p_ready_on_retire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid_o && !flush_i) |-> alloc_ready_o);

    // R9: a flush names a live group
    p_flush_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> live[flush_tag_i]);

endmodule

// File: tb/gsb_group_buffer_bench.sv
module gsb_group_buffer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [2:0]  alloc_cnt = '0;
    logic [63:0] alloc_uops = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic [3:0]  done_valid = '0;
    logic [11:0] done_tag = '0;
    logic        flush = 1'b0;
    logic [2:0]  flush_tag = '0;
    logic        retire_valid;
    logic [2:0]  retire_tag;
    logic [63:0] retire_uops;
    logic [3:0]  retire_nop;

    always #2 clk = ~clk;

    gsb_group_buffer u_gsb_group_buffer (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid_i(alloc_valid), .alloc_cnt_i(alloc_cnt), .alloc_uops_i(alloc_uops),
        .alloc_ready_o(alloc_ready), .alloc_tag_o(alloc_tag),
        .done_valid_i(done_valid), .done_tag_i(done_tag),
        .flush_i(flush), .flush_tag_i(flush_tag),
        .retire_valid_o(retire_valid), .retire_tag_o(retire_tag),
        .retire_uops_o(retire_uops), .retire_nop_o(retire_nop)
    );

    typedef struct {
        int          tag;
        logic [3:0]  nop;
        logic [3:0]  done;
        logic [63:0] uops;
    } ent_t;

    ent_t q[$];
    int   next_tag = 0;
    int   checks = 0;
    int   failures = 0;
    bit   finished = 0;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_ret();
        return q.size() > 0 && q[0].done == 4'hF;
    endfunction

    task automatic model_update();
        bit   ret = m_ret();
        bit   rdy = !flush && (q.size() < 6 || ret);
        ent_t e;
        for (int s = 0; s < 4; s++) begin
            if (done_valid[s]) begin
                for (int i = 0; i < q.size(); i++) begin
                    if (q[i].tag == int'(done_tag[s*3 +: 3])) q[i].done[s] = 1'b1;
                end
            end
        end
        if (ret) void'(q.pop_front());
        if (flush) begin
            while (q.size() > 0 && q[q.size()-1].tag != int'(flush_tag)) void'(q.pop_back());
            next_tag = (int'(flush_tag) + 1) % 6;
        end
        if (alloc_valid && rdy) begin
            e.tag = next_tag;
            for (int s = 0; s < 4; s++) begin
                e.nop[s] = (s >= int'(alloc_cnt));
                e.uops[s*16 +: 16] = e.nop[s] ? 16'h0 : alloc_uops[s*16 +: 16];
            end
            e.done = e.nop;
            q.push_back(e);
            next_tag = (next_tag + 1) % 6;
        end
    endtask

    task automatic compare();
        bit ret = m_ret();
        chk("R3 alloc_ready", 64'(alloc_ready), 64'(!flush && (q.size() < 6 || ret)));
        chk("R2 alloc_tag", 64'(alloc_tag), 64'(next_tag));
        chk("R5 retire_valid", 64'(retire_valid), 64'(ret));
        if (ret) begin
            chk("R5 retire_tag", 64'(retire_tag), 64'(q[0].tag));
            chk("R4 retire_nop", 64'(retire_nop), 64'(q[0].nop));
            chk("R4 retire_uops", retire_uops, q[0].uops);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ready after reset", 64'(alloc_ready), 64'd1);
        chk("R1 no retire after reset", 64'(retire_valid), 64'd0);
        chk("R1 tag after reset", 64'(alloc_tag), 64'd0);

        // fill all six groups with four real micro-ops each
        for (int i = 0; i < 6; i++) begin
            alloc_valid = 1'b1; alloc_cnt = 3'd4;
            alloc_uops = {16'(i*4+3), 16'(i*4+2), 16'(i*4+1), 16'(i*4)} | 64'h1000_1000_1000_1000;
            step();
        end
        chk("R3 full blocks alloc", 64'(alloc_ready), 64'd0);
        chk("R2 tag wraps", 64'(alloc_tag), 64'd0);
        alloc_valid = 1'b0;

        // younger group completes first
        done_valid = 4'hF; done_tag = {4{3'd1}};
        step();
        chk("R5 younger complete waits", 64'(retire_valid), 64'd0);

        // oldest group, half its slots
        done_valid = 4'b0011; done_tag = {4{3'd0}};
        step();
        chk("R7 partial group holds", 64'(retire_valid), 64'd0);
        done_valid = 4'b1100;
        step();
        chk("R6 retire after last done", 64'(retire_valid), 64'd1);
        chk("R6 retire tag", 64'(retire_tag), 64'd0);
        chk("R8 ready while full and retiring", 64'(alloc_ready), 64'd1);

        // allocate in the same cycle as retirement of a full buffer
        done_valid = '0;
        alloc_valid = 1'b1; alloc_cnt = 3'd2; alloc_uops = 64'hDEAD_BEEF_1234_5678;
        step();
        chk("R5 in-order next retire", 64'(retire_valid), 64'd1);
        chk("R5 in-order next tag", 64'(retire_tag), 64'd1);
        chk("R8 accepted while full", 64'(alloc_tag), 64'd1);
        alloc_valid = 1'b0;
        step();
        chk("R5 incomplete head holds", 64'(retire_valid), 64'd0);

        // flush keeping groups 2 and 3
        flush = 1'b1; flush_tag = 3'd3; alloc_valid = 1'b1; alloc_cnt = 3'd4;
        #1;
        chk("R9 ready low during flush", 64'(alloc_ready), 64'd0);
        step();
        flush = 1'b0; alloc_valid = 1'b0;
        chk("R9 tag after flush", 64'(alloc_tag), 64'd4);
        done_valid = 4'hF; done_tag = {4{3'd2}};
        step();
        done_tag = {4{3'd3}};
        step();
        done_valid = '0;
        step();
        chk("R9 flushed groups never retire", 64'(retire_valid), 64'd0);

        // all-NOP group
        alloc_valid = 1'b1; alloc_cnt = 3'd0; alloc_uops = '1;
        step();
        chk("R10 empty group retires next cycle", 64'(retire_valid), 64'd1);
        chk("R10 empty group tag", 64'(retire_tag), 64'd4);
        chk("R4 all slots nop", 64'(retire_nop), 64'hF);
        chk("R4 nop payload zero", retire_uops, 64'd0);

        // one real micro-op
        alloc_cnt = 3'd1;
        step();
        alloc_valid = 1'b0;
        chk("R7 real slot outstanding", 64'(retire_valid), 64'd0);
        done_valid = 4'b0001; done_tag = {4{3'd5}};
        step();
        done_valid = '0;
        chk("R4 partial nop mask", 64'(retire_nop), 64'b1110);
        chk("R4 partial payload", retire_uops, 64'h0000_0000_0000_FFFF);
        step();

        // pseudo-random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            alloc_valid = ($urandom % 4) != 0;
            alloc_cnt   = 3'($urandom % 5);
            alloc_uops  = {$urandom, $urandom};
            done_valid  = 4'($urandom);
            for (int s = 0; s < 4; s++) done_tag[s*3 +: 3] = 3'($urandom % 6);
            flush = 1'b0;
            if (q.size() > 0 && ($urandom % 20) == 0) begin
                flush = 1'b1;
                flush_tag = 3'(q[$urandom % q.size()].tag);
            end
            step();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule